// File: doc/BRIEF.md
# Interrupt Pin Swizzle Router

This block turns level interrupt requests from configuration-space functions into a vector of system IRQ lines. Each function announces which of its four interrupt pins it uses through a pin byte in its configuration space. When the function raises or lowers its request, the router rotates that pin by the function's device number. This picks one of four parent lines. The parent line then selects one byte of a four-entry routing table held in a bridge function's configuration space, and that byte names the IRQ line to drive.

Configuration writes arrive on a byte-wide port carrying a function index, a byte offset and data. Only two kinds of byte are kept: the pin byte of each function and the four routing bytes of the bridge. Requests arrive as single-cycle strobes carrying a function index and a raise or lower flag. Each function holds a remembered "asserting" state. Every IRQ line is the OR of all asserting functions whose route currently lands on it, so lines can be shared.

Top module: `irq_swizzle_router`

## Requirements
- R1: After reset every IRQ output is 0, every stored pin byte is 0 and every routing byte is 8'h80, which means disabled.
- R2: A configuration write to offset 8'h3D of a function below NUM_FUNC stores the data as that function's pin byte. A write to any other offset leaves the pin byte unchanged.
- R3: The device number of a function is its index shifted right by 3. The parent line is ((pin - 1) + (device - 1)) modulo 4.
- R4: Configuration writes to function BRIDGE_FUNC (default 8) at offsets 8'h60 to 8'h63 store routing entries 0 to 3, with entry = offset - 8'h60. An enabled entry drives the IRQ line numbered by its low 4 bits.
- R5: A routing byte with bit 7 set drives no line for any function that maps to that parent line.
- R6: A raise request accepted at a clock edge sets the IRQ line at the following edge, so the line is visible two edges after the request is presented.
- R7: A lower request clears the function's asserting state. Its line falls on the same timing as R6, and the line to lower is recomputed from the current pin and routing.
- R8: A line shared by several functions stays high while at least one of them is still asserting.
- R9: A raise request from a function whose pin byte is 0 or greater than 4 has no effect.
- R10: A request or configuration write naming a function index at or above NUM_FUNC has no effect.
- R11: A new routing byte takes effect on the next clock. An already-asserting function moves to its new line, or falls silent, with the same timing as R6.
- R12: A request and a configuration write presented in the same cycle are both carried out. The raise check of R9 uses the pin byte as it stood before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Interrupt request strobe |
| reqRaise | input | 1 | 1 = raise, 0 = lower |
| reqFunc | input | 8 | Function index of the request |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgFunc | input | 8 | Function index of the write |
| cfgOffset | input | 8 | Configuration byte offset |
| cfgData | input | 8 | Byte to write |
| irqLines | output | NUM_IRQ | Level IRQ outputs, one bit per line |

## Verification
The swizzle is tried with functions on devices 0 through 3 and with several pin values. Each pair is chosen so that a plain pin map, a missing device term or a wrong offset of 1 would land on a different routing entry. Two functions share a line, then lower one at a time, which separates an OR of asserting functions from last-writer behaviour. Routing bytes are rewritten while functions are asserting; this shows whether the table is read live or latched at raise time, and whether bit 7 silences a line. Invalid pins, out-of-range functions, non-pin offsets and a request arriving in the same cycle as a pin write show whether such stimulus is truly ignored or uses the right pin value.

// File: rtl/swz_pkg.sv
package swz_pkg;

  localparam int IDX_W      = 8;
  localparam int NUM_PARENT = 4;

  typedef logic [7:0] cfgByte_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             setAct;
    logic             clrAct;
    logic [IDX_W-1:0] reqIdx;
    logic             pinWr;
    logic             routeWr;
    logic [IDX_W-1:0] cfgIdx;
    logic [1:0]       routeIdx;
    cfgByte_t         wrData;
  } swzStrobe_t;

  // ((pin-1)+(dev-1)) mod 4 == (pin+dev+2) mod 4
  function automatic logic [1:0] swzParent(input cfgByte_t pin, input int dev);
    logic [1:0] devLow;
    devLow = 2'(dev);
    return 2'(pin[1:0] + devLow + 2'd2);
  endfunction

  function automatic logic pinUsable(input cfgByte_t pin);
    return (pin >= 8'd1) && (pin <= 8'd4);
  endfunction

endpackage

// File: rtl/swz_control.sv
module swz_control
  import swz_pkg::*;
#(
  parameter int       NUM_FUNC    = 32,
  parameter int       BRIDGE_FUNC = 8,
  parameter cfgByte_t PIN_OFFSET  = 8'h3D,
  parameter cfgByte_t ROUTE_BASE  = 8'h60
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqRaise,
  input  logic [IDX_W-1:0] reqFunc,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgFunc,
  input  cfgByte_t         cfgOffset,
  input  cfgByte_t         cfgData,
  output swzStrobe_t       stb
);

  logic reqInRange;
  logic cfgInRange;
  logic isRouteOff;
  logic isBridge;

  always_comb begin
    reqInRange = int'(reqFunc) < NUM_FUNC;
    cfgInRange = int'(cfgFunc) < NUM_FUNC;
    isBridge   = int'(cfgFunc) == BRIDGE_FUNC;
    isRouteOff = cfgOffset[7:2] == ROUTE_BASE[7:2];

    stb          = '0;
    stb.reqIdx   = reqFunc;
    stb.cfgIdx   = cfgFunc;
    stb.routeIdx = cfgOffset[1:0];
    stb.wrData   = cfgData;
    stb.setAct   = reqValid && reqRaise && reqInRange;
    stb.clrAct   = reqValid && !reqRaise && reqInRange;
    stb.pinWr    = cfgWrEn && cfgInRange && (cfgOffset == PIN_OFFSET);
    stb.routeWr  = cfgWrEn && isBridge && isRouteOff;
  end

  // R10: out-of-range functions never reach the datapath
  p_req_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setAct || stb.clrAct) |-> (int'(stb.reqIdx) < NUM_FUNC));

  p_one_action_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setAct && stb.clrAct));

endmodule

// File: rtl/swz_lane.sv
module swz_lane
  import swz_pkg::*;
#(
  parameter int DEV     = 0,
  parameter int NUM_IRQ = 16
) (
  input  cfgByte_t                     pin,
  input  logic                         active,
  input  logic [NUM_PARENT*8-1:0]      routeFlat,
  output logic [NUM_IRQ-1:0]           hit
);

  localparam int IRQ_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [1:0] parent;
  cfgByte_t   route;
  logic       drive;

  always_comb begin
    parent = swzParent(pin, DEV);
    route  = routeFlat[parent*8 +: 8];
    drive  = active && pinUsable(pin) && !route[7];
    hit    = '0;
    if (drive) hit = NUM_IRQ'(1) << route[IRQ_W-1:0];
  end

endmodule

// File: rtl/swz_datapath.sv
module swz_datapath
  import swz_pkg::*;
#(
  parameter int NUM_FUNC = 32,
  parameter int NUM_IRQ  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  swzStrobe_t         stb,
  output logic [NUM_IRQ-1:0] irqLines
);

  localparam int FW = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1;

  cfgByte_t              pinReg   [NUM_FUNC];
  cfgByte_t              routeReg [NUM_PARENT];
  logic [NUM_FUNC-1:0]   actReg;
  logic [NUM_IRQ-1:0]    hitVec   [NUM_FUNC];
  logic [NUM_PARENT*8-1:0] routeFlat;
  logic [NUM_IRQ-1:0]    irqNext;
  logic [FW-1:0]         reqSel;
  logic [FW-1:0]         cfgSel;
  logic                  reqPinOk;

  always_comb begin
    reqSel   = stb.reqIdx[FW-1:0];
    cfgSel   = stb.cfgIdx[FW-1:0];
    reqPinOk = pinUsable(pinReg[reqSel]);
    for (int p = 0; p < NUM_PARENT; p++) routeFlat[p*8 +: 8] = routeReg[p];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int f = 0; f < NUM_FUNC; f++) pinReg[f] <= '0;
      for (int p = 0; p < NUM_PARENT; p++) routeReg[p] <= 8'h80;
      actReg <= '0;
    end else begin
      if (stb.pinWr)   pinReg[cfgSel]        <= stb.wrData;
      if (stb.routeWr) routeReg[stb.routeIdx] <= stb.wrData;
      if (stb.setAct && reqPinOk) actReg[reqSel] <= 1'b1;
      if (stb.clrAct)             actReg[reqSel] <= 1'b0;
    end
  end

  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_lane
    swz_lane #(.DEV(f >> 3), .NUM_IRQ(NUM_IRQ)) u_lane (
      .pin      (pinReg[f]),
      .active   (actReg[f]),
      .routeFlat(routeFlat),
      .hit      (hitVec[f])
    );
  end

  always_comb begin
    irqNext = '0;
    for (int f = 0; f < NUM_FUNC; f++) irqNext = irqNext | hitVec[f];
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqLines <= '0;
    else       irqLines <= irqNext;
  end

  p_raise_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setAct && reqPinOk) |=> actReg[$past(reqSel)]);

  p_lower_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAct |=> !actReg[$past(reqSel)]);

  p_bad_pin_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setAct && !reqPinOk && !actReg[reqSel] && !stb.clrAct) |=> !actReg[$past(reqSel)]);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (actReg == '0) |=> (irqLines == '0));

  p_all_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (routeReg[0][7] && routeReg[1][7] && routeReg[2][7] && routeReg[3][7]) |=> (irqLines == '0));

  p_route_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.routeWr |=> (routeReg[$past(stb.routeIdx)] == $past(stb.wrData)));

endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router
  import swz_pkg::*;
#(
  parameter int       NUM_FUNC    = 32,
  parameter int       NUM_IRQ     = 16,
  parameter int       BRIDGE_FUNC = 8,
  parameter cfgByte_t PIN_OFFSET  = 8'h3D,
  parameter cfgByte_t ROUTE_BASE  = 8'h60
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqRaise,
  input  logic [7:0]         reqFunc,
  input  logic               cfgWrEn,
  input  logic [7:0]         cfgFunc,
  input  logic [7:0]         cfgOffset,
  input  logic [7:0]         cfgData,
  output logic [NUM_IRQ-1:0] irqLines
);

  swzStrobe_t stb;

  swz_control #(
    .NUM_FUNC   (NUM_FUNC),
    .BRIDGE_FUNC(BRIDGE_FUNC),
    .PIN_OFFSET (PIN_OFFSET),
    .ROUTE_BASE (ROUTE_BASE)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqRaise (reqRaise),
    .reqFunc  (reqFunc),
    .cfgWrEn  (cfgWrEn),
    .cfgFunc  (cfgFunc),
    .cfgOffset(cfgOffset),
    .cfgData  (cfgData),
    .stb      (stb)
  );

  swz_datapath #(
    .NUM_FUNC(NUM_FUNC),
    .NUM_IRQ (NUM_IRQ)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .irqLines(irqLines)
  );

endmodule

// File: tb/sim_irq_swizzle_router.sv
module sim_irq_swizzle_router;

  localparam int NF = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqRaise = 1'b0, cfgWrEn = 1'b0;
  logic [7:0]  reqFunc = '0, cfgFunc = '0, cfgOffset = '0, cfgData = '0;
  logic [15:0] irqLines;

  irq_swizzle_router u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRaise(reqRaise),
    .reqFunc(reqFunc), .cfgWrEn(cfgWrEn), .cfgFunc(cfgFunc),
    .cfgOffset(cfgOffset), .cfgData(cfgData), .irqLines(irqLines)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycCnt = 0;
  bit done = 0;

  logic [7:0]  pinM   [NF];
  logic [7:0]  routeM [4];
  logic        actM   [NF];

  int          dueQ [$];
  logic [15:0] expQ [$];
  string       tagQ [$];

  always @(posedge clk) cycCnt <= cycCnt + 1;

  function automatic logic [15:0] modelMask();
    logic [15:0] m = '0;
    for (int f = 0; f < NF; f++) begin
      if (actM[f] && pinM[f] >= 1 && pinM[f] <= 4) begin
        int par = ((pinM[f] - 1) + ((f >> 3) - 1) + 8) % 4;
        if (!routeM[par][7]) m[routeM[par][3:0]] = 1'b1;
      end
    end
    return m;
  endfunction

  // monitor: compare outputs when each expectation falls due
  always @(negedge clk) begin
    while (dueQ.size() > 0 && dueQ[0] == cycCnt) begin
      checks++;
      if (irqLines !== expQ[0]) begin
        errors++;
        $display("FAIL %s: irqLines=%h expected=%h", tagQ[0], irqLines, expQ[0]);
      end
      void'(dueQ.pop_front()); void'(expQ.pop_front()); void'(tagQ.pop_front());
    end
  end

  // driver: one cycle of stimulus; model updated request first, then cfg (R12)
  task automatic step(input bit rq, input bit rs, input int rf,
                      input bit cw, input int cf, input int co, input int cd,
                      input string tag);
    reqValid = rq; reqRaise = rs; reqFunc = 8'(rf);
    cfgWrEn = cw; cfgFunc = 8'(cf); cfgOffset = 8'(co); cfgData = 8'(cd);
    if (rq && rf < NF) begin
      if (rs) begin
        if (pinM[rf] >= 1 && pinM[rf] <= 4) actM[rf] = 1'b1;
      end else actM[rf] = 1'b0;
    end
    if (cw && cf < NF && co == 8'h3D) pinM[cf] = 8'(cd);
    if (cw && cf == 8 && co >= 8'h60 && co <= 8'h63) routeM[co - 8'h60] = 8'(cd);
    dueQ.push_back(cycCnt + 2); expQ.push_back(modelMask()); tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 0; cfgWrEn = 0;
  endtask

  task automatic req(input int f, input bit rs, input string tag);
    step(1, rs, f, 0, 0, 0, 0, tag);
  endtask

  task automatic cfg(input int f, input int o, input int d, input string tag);
    step(0, 0, 0, 1, f, o, d, tag);
  endtask

  initial begin
    for (int f = 0; f < NF; f++) begin pinM[f] = 0; actM[f] = 0; end
    for (int p = 0; p < 4; p++) routeM[p] = 8'h80;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (irqLines !== 16'h0) begin
      errors++; $display("FAIL R1: irqLines=%h expected=0000", irqLines);
    end
    // R1: routes disabled after reset, pin set, raise gives nothing
    cfg(0, 8'h3D, 1, "R1 pin write");
    req(0, 1, "R1 routes disabled at reset");
    req(0, 0, "R1 lower");
    // R4: routing table
    cfg(8, 8'h60, 5,  "R4 route0");
    cfg(8, 8'h61, 9,  "R4 route1");
    cfg(8, 8'h62, 10, "R4 route2");
    cfg(8, 8'h63, 11, "R4 route3");
    cfg(8, 8'h3D, 1,  "R2 pin f8");
    cfg(16, 8'h3D, 2, "R2 pin f16");
    cfg(25, 8'h3D, 4, "R2 pin f25");
    cfg(9, 8'h3D, 1,  "R2 pin f9");
    // R3/R6: swizzle on devices 0..3
    req(0, 1,  "R3 dev0 pin1 -> irq11");
    req(8, 1,  "R3 dev1 pin1 -> irq5");
    req(16, 1, "R3 dev2 pin2 -> irq10");
    req(25, 1, "R6 dev3 pin4 -> irq9");
    req(0, 0,  "R7 lower f0");
    req(25, 0, "R7 lower f25");
    // R8: sharing line 5
    req(9, 1, "R8 f9 joins irq5");
    req(8, 0, "R8 irq5 held by f9");
    req(9, 0, "R8 irq5 released");
    // R2: non-pin offset ignored
    cfg(8, 8'h3C, 2, "R2 other offset ignored");
    req(8, 1, "R2 f8 still pin1 -> irq5");
    // R11 / R5: live routing
    cfg(8, 8'h62, 3,    "R11 route2 -> irq3");
    cfg(8, 8'h60, 8'h85, "R5 route0 disabled");
    cfg(8, 8'h60, 8'h07, "R11 route0 -> irq7");
    // R9: invalid pins
    cfg(3, 8'h3D, 0, "R9 pin0 f3");
    req(3, 1, "R9 pin0 raise ignored");
    cfg(4, 8'h3D, 5, "R9 pin5 f4");
    req(4, 1, "R9 pin5 raise ignored");
    // R10: out of range
    req(40, 1, "R10 func40 raise ignored");
    cfg(40, 8'h60, 0, "R10 func40 cfg ignored");
    req(16, 0, "R10 after out-of-range still sane");
    // R12: same-cycle request and cfg
    step(1, 1, 17, 1, 17, 8'h3D, 2, "R12 raise uses old pin0");
    step(1, 1, 17, 1, 8, 8'h61, 12, "R12 raise f17 + route1 write");
    step(1, 0, 8, 1, 8, 8'h63, 14, "R12 lower f8 + route3 write");
    req(17, 0, "R7 lower f17");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule